// File: doc/BRIEF.md
# MDIO management frame engine

This block is a clause-22 MDIO management master driven by three registers. Software stores one packed 32-bit command word in the data register. The engine then sends a preamble of ones and the command bits on MDC/MDIO. For a read frame it releases MDIO from the turnaround onward, shifts in the 16 bits that the PHY returns, and places them in the low half of the data register. Completion raises an event flag. Software clears that flag by writing a one to it.

MDC is derived from the system clock. The divider register holds the speed setting already shifted left by one, so its field sits in bits 6:1. The MDC frequency is f_sys / (2 × field). Software normally writes ceil(f_sys / 5 MHz) << 1, which keeps MDC at or below 2.5 MHz. While no frame is in progress, MDC stays low and MDIO is not driven.

Top module: `mdio_frame_master`

## Requirements
- R1: After reset and whenever idle, `mdc` is 0 and `mdio_oe` is 0; after reset `data_word` and `event_word` read 0.
- R2: A write with `wr_sel` = 0 while idle stores `wr_data` in the data register and starts a frame: 32 bits of one, then the command word from bit 31 down to bit 0, each bit presented while MDC is low and held through the following high half.
- R3: A write with `wr_sel` = 2 loads the divider field from `wr_data[6:1]`. Each MDC half period lasts `field` system clocks, and a field of 0 acts as 1, so consecutive MDC rising edges are 2 × max(field, 1) clocks apart. A `wr_sel` of 3 has no effect.
- R4: A command whose bits 29:28 are 10 is a read: MDIO is released (`mdio_oe` = 0) for the last 18 bits of the frame (command bits 17 down to 0). Every other opcode drives all 64 bits.
- R5: In a read, MDIO is sampled on each MDC rising edge of the last 16 bits, first bit into bit 15. At completion these bits replace `data_word[15:0]` while `data_word[31:16]` is kept. A write frame leaves `data_word` unchanged.
- R6: Completion of a frame sets bit 23 of `event_word`.
- R7: A write with `wr_sel` = 1 clears the event bit when `wr_data[23]` is 1 and leaves it unchanged when that bit is 0. A completion in the same cycle takes precedence.
- R8: A write with `wr_sel` = 0 during a frame is ignored: the frame in flight and the stored word are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 data/command, 1 event, 2 divider |
| wr_data | input | 32 | Register write value |
| mdio_i | input | 1 | MDIO pad input |
| data_word | output | 32 | Data/command register contents |
| event_word | output | 32 | Event register, management-done flag in bit 23 |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable (0 = high impedance) |

## Verification
Write frames with distinct PHY and register addresses and data show whether the preamble, the field order and the bit ordering are right. Read frames returning 0xA5C3, 0x0000 and 0xFFFF show whether the turnaround release is correct, whether capture is MSB first, and whether the upper half of the word is preserved. Divider fields of 1, 3 and 0 are measured against the spacing of MDC rising edges, which tells a correct half period from an off-by-one divider and confirms that a zero field is handled. A second command written mid-frame, and event writes with and without bit 23 set, test the ignore rule and the write-one-to-clear rule.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
    localparam int CMD_W    = 32;
    localparam int RD_W     = 16;
    localparam int EVT_BIT  = 23;
    localparam logic [1:0] OP_RD   = 2'b10;
    localparam logic [1:0] SEL_CMD = 2'd0;
    localparam logic [1:0] SEL_EVT = 2'd1;
    localparam logic [1:0] SEL_DIV = 2'd2;
endpackage

// File: rtl/mdio_half_timer.sv
module mdio_half_timer #(
    parameter int DIV_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] half,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = run && (cnt_q == half - DIV_W'(1));
        cnt_d = cnt_q;
        if (!run || tick) cnt_d = '0;
        else              cnt_d = cnt_q + DIV_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/mdio_frame_shifter.sv
module mdio_frame_shifter
    import mdio_pkg::*;
#(
    parameter int PRE_BITS = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CMD_W-1:0] cmd,
    input  logic             tick,
    input  logic             mdio_i,
    output logic             busy,
    output logic             done,
    output logic             done_rd,
    output logic [RD_W-1:0]  rx_data,
    output logic             mdc,
    output logic             mdio_o,
    output logic             mdio_oe
);
    localparam int FRAME = PRE_BITS + CMD_W;
    localparam int CW    = $clog2(FRAME + 1);
    localparam logic [CW-1:0] LAST     = CW'(FRAME - 1);
    localparam logic [CW-1:0] PRE_END  = CW'(PRE_BITS);
    localparam logic [CW-1:0] TA_FIRST = CW'(PRE_BITS + 14);
    localparam logic [CW-1:0] RX_FIRST = CW'(PRE_BITS + 16);

    typedef struct packed {
        logic             busy;
        logic             mdc;
        logic             rd;
        logic [CW-1:0]    cnt;
        logic [CMD_W-1:0] sh;
        logic [RD_W-1:0]  rx;
    } sh_t;

    sh_t s_d, s_q;

    always_comb begin
        s_d  = s_q;
        done = 1'b0;
        if (!s_q.busy) begin
            if (start) begin
                s_d.busy = 1'b1;
                s_d.mdc  = 1'b0;
                s_d.cnt  = '0;
                s_d.sh   = cmd;
                s_d.rd   = (cmd[29:28] == OP_RD);
                s_d.rx   = '0;
            end
        end else if (tick) begin
            if (!s_q.mdc) begin
                s_d.mdc = 1'b1;
                if (s_q.rd && s_q.cnt >= RX_FIRST)
                    s_d.rx = {s_q.rx[RD_W-2:0], mdio_i};
            end else begin
                s_d.mdc = 1'b0;
                if (s_q.cnt == LAST) begin
                    s_d.busy = 1'b0;
                    done     = 1'b1;
                end else begin
                    s_d.cnt = s_q.cnt + CW'(1);
                    if (s_q.cnt >= PRE_END)
                        s_d.sh = {s_q.sh[CMD_W-2:0], 1'b0};
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy    = s_q.busy;
    assign done_rd = s_q.rd;
    assign rx_data = s_q.rx;
    assign mdc     = s_q.mdc;
    assign mdio_oe = s_q.busy && !(s_q.rd && s_q.cnt >= TA_FIRST);
    assign mdio_o  = s_q.busy && ((s_q.cnt < PRE_END) || s_q.sh[CMD_W-1]);

    // R1: no clock and no drive while idle
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !s_q.busy |-> (!mdc && !mdio_oe));
    // R3: MDC only changes on a timer tick
    p_mdc_on_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.busy && !tick) |=> $stable(mdc));
endmodule

// File: rtl/mdio_frame_master.sv
module mdio_frame_master
    import mdio_pkg::*;
#(
    parameter int PRE_BITS = 32,
    parameter int DIV_W    = 6
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [1:0]  wr_sel,
    input  logic [31:0] wr_data,
    input  logic        mdio_i,
    output logic [31:0] data_word,
    output logic [31:0] event_word,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe
);
    typedef struct packed {
        logic [CMD_W-1:0] data;
        logic             evt;
        logic [DIV_W-1:0] div;
    } reg_t;

    reg_t r_d, r_q;

    logic             busy, done, done_rd, tick, start;
    logic [RD_W-1:0]  rx_data;
    logic [DIV_W-1:0] half;

    always_comb begin
        r_d   = r_q;
        start = wr_en && (wr_sel == SEL_CMD) && !busy;
        half  = (r_q.div == '0) ? DIV_W'(1) : r_q.div;
        if (start)
            r_d.data = wr_data;
        else if (done && done_rd)
            r_d.data = {r_q.data[CMD_W-1:RD_W], rx_data};
        if (wr_en && wr_sel == SEL_DIV)
            r_d.div = wr_data[DIV_W:1];
        if (done)
            r_d.evt = 1'b1;
        else if (wr_en && wr_sel == SEL_EVT && wr_data[EVT_BIT])
            r_d.evt = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    mdio_half_timer #(.DIV_W(DIV_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .run(busy), .half(half), .tick(tick)
    );

    mdio_frame_shifter #(.PRE_BITS(PRE_BITS)) u_shift (
        .clk(clk), .rst_n(rst_n), .start(start), .cmd(wr_data),
        .tick(tick), .mdio_i(mdio_i), .busy(busy), .done(done),
        .done_rd(done_rd), .rx_data(rx_data), .mdc(mdc),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe)
    );

    assign data_word  = r_q.data;
    assign event_word = 32'(r_q.evt) << EVT_BIT;

    // R6: completion raises the event flag
    p_done_sets_event_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> event_word[EVT_BIT]);
    // R7: a write of one clears the flag when no completion competes
    p_w1c_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == SEL_EVT && wr_data[EVT_BIT] && !done) |=> !event_word[EVT_BIT]);
    // R8: command writes during a frame do not reach the stored word
    p_busy_ignore_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wr_en && wr_sel == SEL_CMD) |=> $stable(data_word[31:16]));
endmodule

// File: tb/mdio_frame_master_test.sv
module mdio_frame_master_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [31:0] wr_data = '0;
    logic        mdio_i = 1'b1;
    logic [31:0] data_word, event_word;
    logic        mdc, mdio_o, mdio_oe;

    always #2.5 clk = ~clk;

    mdio_frame_master uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .mdio_i(mdio_i), .data_word(data_word),
        .event_word(event_word), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
    );

    typedef struct {
        logic [31:0] cmd;
        logic [31:0] exp_word;
        int          half;
    } item_t;

    item_t q[$];
    int n_tests = 0;
    int n_fail  = 0;
    logic [15:0] phy_data = '0;
    bit finished = 0;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] sel, input logic [31:0] val);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = val;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // driver: pushes the expected outcome, then issues the command
    task automatic issue(input logic [31:0] cmd, input logic [15:0] pd, input int half);
        item_t it;
        it.cmd  = cmd;
        it.half = half;
        it.exp_word = (cmd[29:28] == 2'b10) ? {cmd[31:16], pd} : cmd;
        q.push_back(it);
        phy_data = pd;
        reg_write(2'd0, cmd);
    endtask

    task automatic wait_done();
        while (!event_word[23]) @(negedge clk);
        @(negedge clk);
        check("R1 idle mdc/oe", {62'd0, mdc, mdio_oe}, 64'd0);
    endtask

    function automatic logic [31:0] mk(input logic [1:0] op, input int pa, input int ra, input logic [15:0] v);
        return {2'b01, op, pa[4:0], ra[4:0], 2'b10, v};
    endfunction

    // monitor: PHY model plus scoreboard comparison at completion
    initial begin
        logic [63:0] bits, oes;
        logic prev_mdc, prev_evt, bad_int;
        int rc, cyc, last_rise, exp_half;
        bits = '0; oes = '0; prev_mdc = 0; prev_evt = 0; bad_int = 0;
        rc = 0; cyc = 0; last_rise = 0; exp_half = 1;
        forever begin
            @(negedge clk);
            cyc++;
            if (q.size() != 0) exp_half = q[0].half;
            if (mdc && !prev_mdc) begin
                if (rc > 0 && (cyc - last_rise) != 2 * exp_half) bad_int = 1;
                last_rise = cyc;
                if (rc < 64) begin
                    bits[63-rc] = mdio_o;
                    oes[63-rc]  = mdio_oe;
                end
                rc++;
            end
            if (!mdc && prev_mdc) begin
                if (rc >= 48 && rc <= 63) mdio_i = phy_data[63-rc];
                else                      mdio_i = 1'b1;
            end
            if (event_word[23] && !prev_evt) begin
                if (q.size() == 0) begin
                    check("R6 unexpected completion", 64'd1, 64'd0);
                end else begin
                    item_t it;
                    logic [63:0] om;
                    it = q.pop_front();
                    om = (it.cmd[29:28] == 2'b10) ? 64'hFFFF_FFFF_FFFC_0000 : '1;
                    check("R2 frame bits", bits & om, {32'hFFFF_FFFF, it.cmd} & om);
                    check("R4 output enable pattern", oes, om);
                    check("R3 mdc rise spacing", {63'd0, bad_int}, 64'd0);
                    check("R5 data word after frame", {32'd0, data_word}, {32'd0, it.exp_word});
                    check("R2 bit count", 64'(rc), 64'd64);
                end
                rc = 0; bad_int = 0; bits = '0; oes = '0;
            end
            prev_mdc = mdc;
            prev_evt = event_word[23];
        end
    end

    initial begin
        int wd = 0;
        while (!finished && wd < 100000) begin
            @(posedge clk);
            wd++;
        end
        if (!finished) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] ca;
        repeat (3) @(negedge clk);
        check("R1 reset outputs", {data_word, event_word}, 64'd0);
        check("R1 reset idle pins", {62'd0, mdc, mdio_oe}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R3: field 1 (register value 2), R2 write frame
        reg_write(2'd2, 32'd2);
        issue(mk(2'b01, 5, 3, 16'h1234), 16'h0, 1);
        wait_done();
        // R7: writing zero keeps, writing bit 23 clears
        reg_write(2'd1, 32'h0000_0000);
        check("R7 zero write keeps event", {63'd0, event_word[23]}, 64'd1);
        reg_write(2'd1, 32'h0080_0000);
        check("R7 one write clears event", {32'd0, event_word}, 64'd0);

        // R4/R5 read frame
        issue(mk(2'b10, 1, 2, 16'h0), 16'hA5C3, 1);
        wait_done();
        reg_write(2'd1, 32'h0080_0000);

        // R3: field 3 (register value 6), select 3 ignored
        reg_write(2'd2, 32'd6);
        reg_write(2'd3, 32'd0);
        issue(mk(2'b10, 0, 0, 16'hBEEF), 16'h0000, 3);
        wait_done();
        reg_write(2'd1, 32'h0080_0000);
        issue(mk(2'b10, 31, 31, 16'h0), 16'hFFFF, 3);
        wait_done();
        reg_write(2'd1, 32'h0080_0000);

        // R3: field 0 acts as 1; R8: mid-frame command ignored
        reg_write(2'd2, 32'd0);
        ca = mk(2'b01, 9, 17, 16'h5AA5);
        issue(ca, 16'h0, 1);
        repeat (40) @(negedge clk);
        reg_write(2'd0, mk(2'b10, 2, 4, 16'h0));
        check("R8 word kept during frame", {32'd0, data_word}, {32'd0, ca});
        wait_done();
        reg_write(2'd1, 32'h0080_0000);
        check("R8 queue drained", 64'(q.size()), 64'd0);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule